// File: doc/BRIEF.md
# Non-Maskable Interrupt Flag Register

This block collects three non-maskable interrupt sources into sticky request flags and presents them to software through a single 16-bit register on a simple synchronous bus. The sources are an asynchronous external NMI line, a one-cycle watchdog overflow pulse and a one-cycle system error pulse. A single request output to the CPU stays high while any flag is set.

The flags have mixed clearing rules. Software clears the external and watchdog flags by writing a one to their bits. The system error flag ignores all writes. It clears only on the synchronous reset or on a self-reset pulse from the watchdog, and that pulse also clears the other two flags. Software can never set a flag. When an event and a clear arrive in the same cycle, the event wins, so no request is lost.

Top module: `nmi_flag_reg`

## Requirements
- R1: After reset, or while `rst` is high at a clock edge, all three flags are 0, `nmi_req` is 0 and the register reads 0x0000.
- R2: The register sits at `REG_ADDR` (default 0x34000100). Bit 0 is the external flag, bit 1 is the watchdog flag and bit 2 is the system error flag. A value of 1 means a request is pending. Bits 15..3 always read 0.
- R3: A rising edge on `ext_nmi_in` sets bit 0 exactly `SYNC_STAGES`+1 clock edges after the input is first sampled high. Keeping the input high afterwards does not set the flag again once it has been cleared.
- R4: A one-cycle `wdt_ovf_pulse` sets bit 1 at that clock edge.
- R5: A write to `REG_ADDR` with a 1 in bit 0 or bit 1 clears that flag if it is set. A 0 in that bit leaves the flag unchanged, and the other flag is not affected.
- R6: No write value sets any flag. Writing 0xFFFF while the flags are 0 leaves the register at 0x0000 and `nmi_req` low.
- R7: Writes never clear bit 2. A one-cycle `sys_err_pulse` sets it, and it stays set until `rst` or `wdt_self_rst`.
- R8: A one-cycle `wdt_self_rst` clears all three flags at that clock edge. It wins over any source event in the same cycle.
- R9: When a source event and a clearing write to the same flag fall in the same cycle, the flag is 1 afterwards.
- R10: `nmi_req` is high exactly while at least one flag is 1.
- R11: Writes to any address other than `REG_ADDR` change no flag. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (pin reset) |
| wdt_self_rst | input | 1 | One-cycle watchdog self-reset pulse; clears all flags |
| ext_nmi_in | input | 1 | Asynchronous external NMI line, rising edge sensitive |
| wdt_ovf_pulse | input | 1 | One-cycle watchdog overflow event |
| sys_err_pulse | input | 1 | One-cycle system error event |
| bus_addr | input | ADDR_W | Bus address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| nmi_req | output | 1 | Non-maskable interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: `SYNC_STAGES` = 2, a 32-bit address and the register at 0x34000100. With these values the external edge can be checked at its exact three-edge latency, and a neighbouring address two bytes away can be used to show that decode misses are ignored. The bench drives all same-cycle collisions directly: an event against a clearing write, and a self-reset against pending flags. It also checks that a held-high external line produces only one request.

// File: rtl/nmi_flag_pkg.sv
package nmi_flag_pkg;

    localparam int unsigned NUM_SRC   = 3;
    localparam int unsigned BIT_EXT   = 0;
    localparam int unsigned BIT_WDT   = 1;
    localparam int unsigned BIT_SYS   = 2;

    typedef struct packed {
        logic sys_err;
        logic wdt_ovf;
        logic ext_nmi;
    } nmi_flags_t;

    typedef struct packed {
        logic soft_clr;
        logic set_ev;
        logic wr_clr;
    } flag_ctl_t;

    function automatic logic flag_next(input logic cur, input flag_ctl_t c);
        logic n;
        if (c.soft_clr)      n = 1'b0;
        else if (c.set_ev)   n = 1'b1;
        else if (c.wr_clr)   n = 1'b0;
        else                 n = cur;
        return n;
    endfunction

    function automatic logic any_pending(input nmi_flags_t f);
        return f.sys_err | f.wdt_ovf | f.ext_nmi;
    endfunction

endpackage

// File: rtl/nmi_edge_sync.sv
module nmi_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q[0] <= async_in;
            prev_q     <= chain_q[LAST];
        end
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= 1'b0;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign rise_pulse = chain_q[LAST] & ~prev_q;

    // R3: an edge produces a single-cycle pulse only
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/nmi_flag_cell.sv
module nmi_flag_cell
    import nmi_flag_pkg::*;
#(
    parameter bit CLEARABLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic soft_clr,
    input  logic set_ev,
    input  logic wr_clr,
    output logic flag_q
);
    flag_ctl_t ctl;

    always_comb begin
        ctl.soft_clr = soft_clr;
        ctl.set_ev   = set_ev;
        ctl.wr_clr   = CLEARABLE ? wr_clr : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_next(flag_q, ctl);
    end

    // R9: a source event always leaves the flag set unless a self-reset arrives
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (set_ev && !soft_clr) |=> flag_q);

    // R6: nothing but an event raises the flag
    p_no_sw_set_r6: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !set_ev) |=> !flag_q);

    // R8: self-reset empties the flag
    p_soft_clear_r8: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> !flag_q);

    generate
        if (CLEARABLE) begin : g_w1c
            // R5: write-one clears a set flag
            p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
                (flag_q && wr_clr && !set_ev) |=> !flag_q);
            p_hold_r5: assert property (@(posedge clk) disable iff (rst)
                (flag_q && !wr_clr && !soft_clr) |=> flag_q);
        end else begin : g_sticky
            // R7: writes cannot clear this flag
            p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
                (flag_q && !soft_clr) |=> flag_q);
        end
    endgenerate

endmodule

// File: rtl/nmi_flag_reg.sv
module nmi_flag_reg
    import nmi_flag_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 32'h3400_0100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wdt_self_rst,
    input  logic              ext_nmi_in,
    input  logic              wdt_ovf_pulse,
    input  logic              sys_err_pulse,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nmi_req
);
    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    logic              hit;
    logic              wr_hit;
    logic              ext_rise;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] flag_vec;
    nmi_flags_t        flags;

    assign hit    = (bus_addr == REG_ADDR);
    assign wr_hit = hit & bus_we;

    nmi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   (ext_nmi_in),
        .rise_pulse (ext_rise)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_EXT] = ext_rise;
        set_vec[BIT_WDT] = wdt_ovf_pulse;
        set_vec[BIT_SYS] = sys_err_pulse;
        clr_vec          = bus_wdata[NUM_SRC-1:0] & {NUM_SRC{wr_hit}};
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
            nmi_flag_cell #(.CLEARABLE(i != BIT_SYS)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .soft_clr (wdt_self_rst),
                .set_ev   (set_vec[i]),
                .wr_clr   (clr_vec[i]),
                .flag_q   (flag_vec[i])
            );
        end
    endgenerate

    always_comb begin
        flags.ext_nmi = flag_vec[BIT_EXT];
        flags.wdt_ovf = flag_vec[BIT_WDT];
        flags.sys_err = flag_vec[BIT_SYS];
    end

    assign nmi_req   = any_pending(flags);
    assign bus_rdata = hit ? {{PAD_W{1'b0}}, flags.sys_err, flags.wdt_ovf, flags.ext_nmi}
                           : '0;

    // R8: request drops after self-reset
    p_selfrst_req_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_self_rst |=> !nmi_req);

    // R11: a write elsewhere cannot clear a pending request
    p_miss_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !hit && !wdt_self_rst) |=> nmi_req);

    // R4: a watchdog pulse raises the request
    p_wdt_req_r4: assert property (@(posedge clk) disable iff (rst)
        (wdt_ovf_pulse && !wdt_self_rst) |=> nmi_req);

endmodule

// File: tb/tb_nmi_flag_reg.sv
module tb_nmi_flag_reg;

    localparam logic [31:0] A_REG  = 32'h3400_0100;
    localparam logic [31:0] A_MISS = 32'h3400_0102;

    logic        clk = 1'b0;
    logic        rst;
    logic        wdt_self_rst;
    logic        ext_nmi_in;
    logic        wdt_ovf_pulse;
    logic        sys_err_pulse;
    logic [31:0] bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        nmi_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    nmi_flag_reg dut (
        .clk           (clk),
        .rst           (rst),
        .wdt_self_rst  (wdt_self_rst),
        .ext_nmi_in    (ext_nmi_in),
        .wdt_ovf_pulse (wdt_ovf_pulse),
        .sys_err_pulse (sys_err_pulse),
        .bus_addr      (bus_addr),
        .bus_we        (bus_we),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .nmi_req       (nmi_req)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic read_chk(input string tag, input logic [15:0] exp);
        bus_addr = A_REG;
        bus_we   = 1'b0;
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    task automatic req_chk(input string tag, input logic exp);
        check(tag, {15'd0, nmi_req}, {15'd0, exp});
    endtask

    task automatic wr(input logic [31:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        step();
        bus_we    = 1'b0;
    endtask

    task automatic pulse_wdt();
        wdt_ovf_pulse = 1'b1; step(); wdt_ovf_pulse = 1'b0;
    endtask

    task automatic pulse_sys();
        sys_err_pulse = 1'b1; step(); sys_err_pulse = 1'b0;
    endtask

    task automatic t_reset();
        read_chk("R1 reset read", 16'h0000);
        req_chk("R1 reset req", 1'b0);
    endtask

    task automatic t_ext_edge();
        ext_nmi_in = 1'b1;
        step(); step();
        read_chk("R3 not yet set", 16'h0000);
        step();
        read_chk("R3 ext flag bit0", 16'h0001);
        req_chk("R10 req with ext", 1'b1);
        repeat (4) step();
        wr(A_REG, 16'h0001);
        read_chk("R5 ext cleared", 16'h0000);
        repeat (5) step();
        read_chk("R3 held high no retrigger", 16'h0000);
        req_chk("R10 req low", 1'b0);
        ext_nmi_in = 1'b0;
        repeat (4) step();
    endtask

    task automatic t_wdt();
        pulse_wdt();
        read_chk("R4 wdt flag bit1", 16'h0002);
        wr(A_REG, 16'h0000);
        read_chk("R5 write zero keeps", 16'h0002);
        wr(A_REG, 16'h0001);
        read_chk("R5 other bit untouched", 16'h0002);
        wr(A_REG, 16'h0002);
        read_chk("R5 wdt cleared", 16'h0000);
    endtask

    task automatic t_no_sw_set();
        wr(A_REG, 16'hFFFF);
        read_chk("R6 no software set", 16'h0000);
        req_chk("R6 req stays low", 1'b0);
    endtask

    task automatic t_sys();
        pulse_sys();
        read_chk("R2 sys flag bit2", 16'h0004);
        wr(A_REG, 16'hFFFF);
        read_chk("R7 sys ignores write", 16'h0004);
        req_chk("R10 req with sys", 1'b1);
    endtask

    task automatic t_self_rst();
        pulse_wdt();
        read_chk("R2 two flags", 16'h0006);
        wdt_self_rst = 1'b1; step(); wdt_self_rst = 1'b0;
        read_chk("R8 self reset clears", 16'h0000);
        req_chk("R8 req low", 1'b0);
        wdt_self_rst  = 1'b1;
        wdt_ovf_pulse = 1'b1;
        step();
        wdt_self_rst  = 1'b0;
        wdt_ovf_pulse = 1'b0;
        read_chk("R8 wins over event", 16'h0000);
    endtask

    task automatic t_other_addr();
        pulse_wdt();
        wr(A_MISS, 16'h0002);
        read_chk("R11 miss write ignored", 16'h0002);
        bus_addr = A_MISS;
        #0.5;
        check("R11 miss read zero", bus_rdata, 16'h0000);
        wr(A_REG, 16'h0002);
        read_chk("R5 cleared after miss", 16'h0000);
    endtask

    task automatic t_set_wins();
        wdt_ovf_pulse = 1'b1;
        bus_addr = A_REG; bus_wdata = 16'h0002; bus_we = 1'b1;
        step();
        wdt_ovf_pulse = 1'b0; bus_we = 1'b0;
        read_chk("R9 event beats clear from 0", 16'h0002);
        wdt_ovf_pulse = 1'b1;
        bus_wdata = 16'h0002; bus_we = 1'b1;
        step();
        wdt_ovf_pulse = 1'b0; bus_we = 1'b0;
        read_chk("R9 event beats clear from 1", 16'h0002);
    endtask

    task automatic t_pin_reset();
        pulse_sys();
        read_chk("R7 sys set before rst", 16'h0006);
        rst = 1'b1; step(); rst = 1'b0;
        read_chk("R1 rst clears all", 16'h0000);
        req_chk("R1 req after rst", 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wdt_self_rst = 1'b0; ext_nmi_in = 1'b0;
        wdt_ovf_pulse = 1'b0; sys_err_pulse = 1'b0;
        bus_addr = A_REG; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_ext_edge();
        t_wdt();
        t_no_sw_set();
        t_sys();
        t_self_rst();
        t_other_addr();
        t_set_wins();
        t_pin_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule